// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the operand address of a memory access for a 16-bit processor with segmented memory. A 5-bit form code picks which terms make up the 16-bit offset: a base register, an index register and a constant displacement, each optional. The base register is BX or BP. The index register is SI or DI. The displacement is 8 or 16 bits wide. The block then picks a segment register. By default that is the stack segment for any form that uses BP, and the data segment for every other form. An override input can force one of the four segments instead. The physical address is the segment value shifted left by four bits, plus the offset.

When the valid strobe is high, the block samples its inputs and presents the results on the following clock edge. The results are the offset, the chosen segment and the physical address of the first byte. The block also gives the physical address of the second byte of a word access. Codes that name no legal form are flagged as illegal. Instruction decoding, the memory access itself and register writeback are handled elsewhere.

Top module: `ea_gen`

## Requirements
- R1: The offset is the sum of the terms the form selects. The sum wraps modulo 65536.
- R2: Form codes are assigned as follows:
  - 0: displacement alone.
  - 1 to 4: BX, SI, DI or BP alone.
  - 5 to 8: BX, SI, DI or BP plus a displacement.
  - 9 to 12: BX+SI, BX+DI, BP+SI or BP+DI.
  - 13 to 16: those four pairs plus a displacement.
- R3: When `disp_wide_i` is 0, the displacement is `disp_i[7:0]` sign-extended to 16 bits. When it is 1, the displacement is all of `disp_i`.
- R4: With no override, a form that uses BP (4, 8, 11, 12, 15 and 16) selects SS. Every other legal form selects DS. Segment ids are CS=0, DS=1, ES=2 and SS=3.
- R5: When `ovr_en_i` is 1, `ovr_seg_i` (same ids as R4) replaces the default segment for every legal form.
- R6: `phys_o` equals (segment value × 16 + offset) mod 2^20.
- R7: `phys_hi_o` equals (segment value × 16 + ((offset + 1) mod 65536)) mod 2^20.
- R8: Codes 17 to 31 set `illegal_o`. For these codes, `offset_o`, `seg_id_o`, `seg_val_o`, `phys_o` and `phys_hi_o` are 0.
- R9: Results appear on the clock edge after a cycle with `valid_i` high. `done_o` is high for exactly that one cycle. The results hold while `valid_i` stays low.
- R10: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Sample request |
| mode_i | input | 5 | Form code |
| bx_i | input | 16 | BX base register |
| bp_i | input | 16 | BP base register |
| si_i | input | 16 | SI index register |
| di_i | input | 16 | DI index register |
| cs_i | input | 16 | Code segment |
| ds_i | input | 16 | Data segment |
| es_i | input | 16 | Extra segment |
| ss_i | input | 16 | Stack segment |
| disp_i | input | 16 | Displacement field |
| disp_wide_i | input | 1 | 1 selects a 16-bit displacement, 0 selects 8-bit |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment id |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Form code is not legal |
| offset_o | output | 16 | Offset |
| seg_id_o | output | 2 | Selected segment id |
| seg_val_o | output | 16 | Selected segment value |
| phys_o | output | 20 | Physical address of the first byte |
| phys_hi_o | output | 20 | Physical address of the second byte |

## Verification
A sweep applies all 32 form codes. Each code is tried with no override and with each of the four overrides. The base and index registers and the four segments are set to distinct values, so a wrong register choice, a wrong default segment or an override that fails to take effect shows up as a different address. A vector table adds the three textbook check points, along with cases that tell sign extension from zero extension and cases where the offset wraps. A segment near the top of memory makes the 20-bit physical sum wrap. The directed tests cover reset, hold after the done pulse, and an offset of FFFFh, where only the second-byte address wraps.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int OFS_W     = 16;
    localparam int SEG_W     = 16;
    localparam int PHYS_W    = 20;
    localparam int MODE_W    = 5;
    localparam int SHORT_W   = 8;
    localparam int NUM_FORMS = 17;
    localparam int SEG_SHIFT = PHYS_W - SEG_W;

    typedef enum logic [1:0] {
        SEG_CS = 2'd0,
        SEG_DS = 2'd1,
        SEG_ES = 2'd2,
        SEG_SS = 2'd3
    } seg_id_t;

    typedef struct packed {
        logic legal;
        logic use_base;
        logic base_bp;
        logic use_index;
        logic index_di;
        logic use_disp;
    } form_t;

    function automatic logic [PHYS_W-1:0] phys_of(input logic [SEG_W-1:0] seg,
                                                  input logic [OFS_W-1:0] ofs);
        return PHYS_W'({seg, {SEG_SHIFT{1'b0}}}) + PHYS_W'(ofs);
    endfunction
endpackage

// File: rtl/ea_form_decode.sv
module ea_form_decode
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output form_t             form_o
);
    logic [MODE_W-1:0] single_idx;
    logic [MODE_W-1:0] pair_idx;

    assign single_idx = mode_i - MODE_W'(1);
    assign pair_idx   = mode_i - MODE_W'(9);

    always_comb begin
        form_o = '0;
        if (mode_i == '0) begin
            form_o.legal    = 1'b1;
            form_o.use_disp = 1'b1;
        end else if (mode_i <= MODE_W'(8)) begin
            form_o.legal    = 1'b1;
            form_o.use_disp = (mode_i >= MODE_W'(5));
            case (single_idx[1:0])
                2'd0: form_o.use_base = 1'b1;
                2'd1: form_o.use_index = 1'b1;
                2'd2: begin
                    form_o.use_index = 1'b1;
                    form_o.index_di  = 1'b1;
                end
                default: begin
                    form_o.use_base = 1'b1;
                    form_o.base_bp  = 1'b1;
                end
            endcase
        end else if (mode_i < MODE_W'(NUM_FORMS)) begin
            form_o.legal     = 1'b1;
            form_o.use_base  = 1'b1;
            form_o.use_index = 1'b1;
            form_o.base_bp   = pair_idx[1];
            form_o.index_di  = pair_idx[0];
            form_o.use_disp  = (mode_i >= MODE_W'(13));
        end
    end
endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
    import ea_pkg::*;
(
    input  form_t            form_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic             disp_wide_i,
    output logic [OFS_W-1:0] offset_o
);
    logic [OFS_W-1:0] base_t, index_t, disp_t, disp_ext;

    assign disp_ext = disp_wide_i ? disp_i
                    : {{(OFS_W-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};

    always_comb begin
        base_t   = form_i.use_base  ? (form_i.base_bp  ? bp_i : bx_i) : '0;
        index_t  = form_i.use_index ? (form_i.index_di ? di_i : si_i) : '0;
        disp_t   = form_i.use_disp  ? disp_ext : '0;
        offset_o = base_t + index_t + disp_t;
    end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
    import ea_pkg::*;
(
    input  form_t            form_i,
    input  logic             ovr_en_i,
    input  logic [1:0]       ovr_seg_i,
    input  logic [SEG_W-1:0] cs_i,
    input  logic [SEG_W-1:0] ds_i,
    input  logic [SEG_W-1:0] es_i,
    input  logic [SEG_W-1:0] ss_i,
    output seg_id_t          seg_id_o,
    output logic [SEG_W-1:0] seg_val_o
);
    seg_id_t dflt;

    assign dflt     = (form_i.use_base && form_i.base_bp) ? SEG_SS : SEG_DS;
    assign seg_id_o = ovr_en_i ? seg_id_t'(ovr_seg_i) : dflt;

    always_comb begin
        case (seg_id_o)
            SEG_CS:  seg_val_o = cs_i;
            SEG_DS:  seg_val_o = ds_i;
            SEG_ES:  seg_val_o = es_i;
            default: seg_val_o = ss_i;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [OFS_W-1:0]  bx_i,
    input  logic [OFS_W-1:0]  bp_i,
    input  logic [OFS_W-1:0]  si_i,
    input  logic [OFS_W-1:0]  di_i,
    input  logic [SEG_W-1:0]  cs_i,
    input  logic [SEG_W-1:0]  ds_i,
    input  logic [SEG_W-1:0]  es_i,
    input  logic [SEG_W-1:0]  ss_i,
    input  logic [OFS_W-1:0]  disp_i,
    input  logic              disp_wide_i,
    input  logic              ovr_en_i,
    input  logic [1:0]        ovr_seg_i,
    output logic              done_o,
    output logic              illegal_o,
    output logic [OFS_W-1:0]  offset_o,
    output logic [1:0]        seg_id_o,
    output logic [SEG_W-1:0]  seg_val_o,
    output logic [PHYS_W-1:0] phys_o,
    output logic [PHYS_W-1:0] phys_hi_o
);
    form_t            frm;
    logic [OFS_W-1:0] ofs_c;
    seg_id_t          sid_c;
    logic [SEG_W-1:0] sval_c;

    ea_form_decode u_dec (.mode_i(mode_i), .form_o(frm));

    ea_offset_sum u_sum (
        .form_i(frm), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .disp_i(disp_i), .disp_wide_i(disp_wide_i), .offset_o(ofs_c)
    );

    ea_seg_pick u_seg (
        .form_i(frm), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
        .cs_i(cs_i), .ds_i(ds_i), .es_i(es_i), .ss_i(ss_i),
        .seg_id_o(sid_c), .seg_val_o(sval_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            offset_o  <= '0;
            seg_id_o  <= '0;
            seg_val_o <= '0;
            phys_o    <= '0;
            phys_hi_o <= '0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                illegal_o <= !frm.legal;
                if (frm.legal) begin
                    offset_o  <= ofs_c;
                    seg_id_o  <= sid_c;
                    seg_val_o <= sval_c;
                    phys_o    <= phys_of(sval_c, ofs_c);
                    phys_hi_o <= phys_of(sval_c, OFS_W'(ofs_c + OFS_W'(1)));
                end else begin
                    offset_o  <= '0;
                    seg_id_o  <= '0;
                    seg_val_o <= '0;
                    phys_o    <= '0;
                    phys_hi_o <= '0;
                end
            end
        end
    end

    p_done_after_valid_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(offset_o) && $stable(phys_o) && $stable(seg_id_o)));

    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (offset_o == '0 && phys_o == '0 && phys_hi_o == '0 && seg_val_o == '0));

    p_illegal_code_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (illegal_o == ($past(mode_i) >= MODE_W'(NUM_FORMS))));

    p_override_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !illegal_o && $past(ovr_en_i)) |-> (seg_id_o == $past(ovr_seg_i)));

    p_default_seg_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && !illegal_o && !$past(ovr_en_i)) |->
        (seg_id_o == (($past(frm.use_base) && $past(frm.base_bp)) ? 2'd3 : 2'd1)));

    p_second_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !illegal_o) |->
        (phys_hi_o == phys_of(seg_val_o, OFS_W'(offset_o + OFS_W'(1)))));
endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [4:0]  mode;
        logic [15:0] bx, bp, si, di, disp;
        logic        wide, oen;
        logic [1:0]  osel;
    } vec_t;

    // form, bx, bp, si, di, disp, wide, oen, osel
    localparam vec_t VECS [NVEC] = '{
        '{5'd5,  16'h1000, 16'h0000, 16'h0000, 16'h0000, 16'h0020, 1'b0, 1'b0, 2'd0},
        '{5'd8,  16'h0000, 16'h2020, 16'h0000, 16'h0000, 16'h1000, 1'b1, 1'b0, 2'd0},
        '{5'd9,  16'h1000, 16'h0000, 16'h0880, 16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0},
        '{5'd12, 16'h0000, 16'h1598, 16'h0000, 16'h1004, 16'h0000, 1'b0, 1'b0, 2'd0},
        '{5'd13, 16'h0100, 16'h0000, 16'h0200, 16'h0000, 16'h0100, 1'b1, 1'b0, 2'd0},
        '{5'd6,  16'h0000, 16'h0000, 16'h0100, 16'h0000, 16'h12FF, 1'b0, 1'b0, 2'd0},
        '{5'd6,  16'h0000, 16'h0000, 16'h0100, 16'h0000, 16'h12FF, 1'b1, 1'b0, 2'd0},
        '{5'd10, 16'hFFFF, 16'h0000, 16'h0000, 16'h0002, 16'h0000, 1'b0, 1'b1, 2'd2},
        '{5'd16, 16'h0000, 16'hFF00, 16'h0000, 16'h00F0, 16'h0080, 1'b0, 1'b1, 2'd0},
        '{5'd0,  16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 2'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_i = 1'b0;
    logic [4:0] mode_i = '0;
    logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0, disp_i = '0;
    logic [15:0] cs_i = 16'hA000, ds_i = 16'h1100, es_i = 16'h2200, ss_i = 16'hFFF0;
    logic disp_wide_i = 1'b0, ovr_en_i = 1'b0;
    logic [1:0] ovr_seg_i = '0;
    logic done_o, illegal_o;
    logic [15:0] offset_o, seg_val_o;
    logic [1:0] seg_id_o;
    logic [19:0] phys_o, phys_hi_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .cs_i(cs_i), .ds_i(ds_i), .es_i(es_i), .ss_i(ss_i),
        .disp_i(disp_i), .disp_wide_i(disp_wide_i),
        .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
        .done_o(done_o), .illegal_o(illegal_o), .offset_o(offset_o),
        .seg_id_o(seg_id_o), .seg_val_o(seg_val_o),
        .phys_o(phys_o), .phys_hi_o(phys_hi_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_ofs(input vec_t v);
        logic [15:0] d;
        d = v.wide ? v.disp : {{8{v.disp[7]}}, v.disp[7:0]};
        case (v.mode)
            5'd0:  return d;
            5'd1:  return v.bx;
            5'd2:  return v.si;
            5'd3:  return v.di;
            5'd4:  return v.bp;
            5'd5:  return v.bx + d;
            5'd6:  return v.si + d;
            5'd7:  return v.di + d;
            5'd8:  return v.bp + d;
            5'd9:  return v.bx + v.si;
            5'd10: return v.bx + v.di;
            5'd11: return v.bp + v.si;
            5'd12: return v.bp + v.di;
            5'd13: return v.bx + v.si + d;
            5'd14: return v.bx + v.di + d;
            5'd15: return v.bp + v.si + d;
            5'd16: return v.bp + v.di + d;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [1:0] ref_seg(input vec_t v);
        if (v.oen) return v.osel;
        case (v.mode)
            5'd4, 5'd8, 5'd11, 5'd12, 5'd15, 5'd16: return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic [15:0] seg_value(input logic [1:0] id);
        case (id)
            2'd0: return cs_i;
            2'd1: return ds_i;
            2'd2: return es_i;
            default: return ss_i;
        endcase
    endfunction

    function automatic logic [19:0] ref_phys(input logic [15:0] sv, input logic [15:0] o);
        logic [31:0] t;
        t = {16'h0, sv} * 32'd16 + {16'h0, o};
        return t[19:0];
    endfunction

    task automatic apply(input vec_t v);
        logic [15:0] eo, sv, eo1;
        logic [1:0]  es;
        logic        ill;
        @(negedge clk);
        mode_i = v.mode; bx_i = v.bx; bp_i = v.bp; si_i = v.si; di_i = v.di;
        disp_i = v.disp; disp_wide_i = v.wide; ovr_en_i = v.oen; ovr_seg_i = v.osel;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        ill = (v.mode > 5'd16);
        eo  = ref_ofs(v);
        es  = ref_seg(v);
        sv  = seg_value(es);
        eo1 = eo + 16'd1;
        chk("R9 done", {31'b0, done_o}, 32'd1);
        chk("R2/R8 illegal", {31'b0, illegal_o}, {31'b0, ill});
        if (ill) begin
            chk("R8 offset zero", {16'b0, offset_o}, 32'd0);
            chk("R8 seg zero", {14'b0, seg_id_o, seg_val_o}, 32'd0);
            chk("R8 phys zero", {12'b0, phys_o}, 32'd0);
            chk("R8 phys_hi zero", {12'b0, phys_hi_o}, 32'd0);
        end else begin
            chk("R1/R3 offset", {16'b0, offset_o}, {16'b0, eo});
            chk(v.oen ? "R5 override seg" : "R4 default seg", {30'b0, seg_id_o}, {30'b0, es});
            chk("R4/R5 seg value", {16'b0, seg_val_o}, {16'b0, sv});
            chk("R6 phys", {12'b0, phys_o}, {12'b0, ref_phys(sv, eo)});
            chk("R7 phys_hi", {12'b0, phys_hi_o}, {12'b0, ref_phys(sv, eo1)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 done reset", {31'b0, done_o}, 32'd0);
        chk("R10 outputs reset", {12'b0, phys_o | phys_hi_o}, 32'd0);
        chk("R10 offset reset", {15'b0, illegal_o, offset_o}, 32'd0);
        rst = 1'b0;

        // Table of vectors, including textbook points R1 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) apply(VECS[i]);

        // Explicit textbook values
        apply(VECS[0]);
        chk("R1 DS:1020", {14'b0, seg_id_o, offset_o}, {14'b0, 2'd1, 16'h1020});
        apply(VECS[1]);
        chk("R4 SS:3020", {14'b0, seg_id_o, offset_o}, {14'b0, 2'd3, 16'h3020});
        apply(VECS[2]);
        chk("R1 DS:1880", {14'b0, seg_id_o, offset_o}, {14'b0, 2'd1, 16'h1880});
        apply(VECS[5]);
        chk("R3 short disp sext", {16'b0, offset_o}, 32'h00FF);
        apply(VECS[6]);
        chk("R3 wide disp", {16'b0, offset_o}, 32'h13FF);
        apply(VECS[9]);
        chk("R7 offset FFFF wraps second byte", {12'b0, phys_hi_o}, {12'b0, ref_phys(ds_i, 16'h0000)});

        // Sweep: every code with no override and all four overrides
        for (int m = 0; m < 32; m++) begin
            for (int o = 0; o < 5; o++) begin
                v.mode = 5'(m); v.bx = 16'h1234; v.bp = 16'hF0F0; v.si = 16'h0F0F; v.di = 16'h8001;
                v.disp = (m % 2 == 0) ? 16'h4480 : 16'h7F05; v.wide = (m % 3 == 0);
                v.oen = (o < 4); v.osel = 2'(o);
                apply(v);
            end
        end

        // R9: hold and single-cycle done
        v = VECS[4];
        apply(v);
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done_o}, 32'd0);
        chk("R9 offset held", {16'b0, offset_o}, {16'b0, ref_ofs(v)});
        bx_i = 16'h5555; mode_i = 5'd1;
        @(negedge clk);
        chk("R9 ignore inputs without valid", {16'b0, offset_o}, {16'b0, ref_ofs(v)});

        // R10: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset clears", {12'b0, phys_o}, 32'd0);
        chk("R10 reset clears seg", {14'b0, seg_id_o, seg_val_o}, 32'd0);
        rst = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule